// File: doc/BRIEF.md
# UART Receive-Error Status and Interrupt Controller

This block holds the status and interrupt logic of a memory-mapped serial port. Single-cycle pulses from the serializer and FIFO logic come in on strobe inputs. Receive parity, framing and overrun errors and transmit overrun errors are caught in sticky flags. Each flag catches its error only while software has enabled the matching check in a control word. The block also keeps the receiver-enable bit.

Software never writes the flag word directly. It writes a separate action word in which each bit either clears one flag or sets or clears the receiver enable, so no read-modify-write is needed. Four interrupt sources each have a pending flag: transmit done, receive ready, error and transmit-buffer free. Each source also has an enable bit and a write-one-to-clear bit. An interrupt line is high when its source is both pending and enabled.

Register map (byte offsets on an 8-bit address): control 0x00, flag word 0x04, action word 0x08, interrupt enable 0x0C, interrupt clear 0x10, raw pending 0x14. Reads are combinational on `reg_addr`. A write takes effect at the clock edge where `reg_wr` is high.

Top module: `usi_top`

## Requirements
- R1: After reset, every register reads zero, `rx_enable` is low and all four interrupt lines are low.
- R2: The control word at 0x00 stores check-enable bits only at bit 16 (parity), 17 (framing), 19 (receive overrun) and 20 (transmit overrun). Every other bit reads zero.
- R3: A strobe on a receive error input sets its flag in the word at 0x04 only when its check bit is set and `rx_enable` is high. Parity sets bit 16, framing sets bit 17 and receive overrun sets bit 19. A transmit overrun strobe sets bit 20 whenever control bit 20 is set. Bit 0 of the word at 0x04 mirrors `rx_enable`.
- R4: A flag stays set until a write to the action word 0x08 clears it. Bit 2 clears parity, bit 3 clears framing, bit 5 clears receive overrun and bit 6 clears transmit overrun. Any mix of flags can be cleared in one write, and flags whose bits are zero are not affected.
- R5: In the action word, bit 1 sets the receiver enable and bit 0 clears it. When both bits are written in the same cycle, the set wins.
- R6: When an event and a clear of the same flag or pending bit arrive in the same cycle, the bit stays set.
- R7: The enable word at 0x0C stores bit 0 (transmit), bit 1 (receive), bit 2 (error) and bit 3 (transmit-buffer). Each interrupt line is its pending bit ANDed with its enable bit.
- R8: The raw pending word at 0x14 records these events: bit 0 from a transmit-done strobe, bit 1 from a receive-ready strobe, bit 3 from a transmit-buffer strobe, and bit 2 from any error strobe that sets a flag under R3.
- R9: Writing one to bit 0 to 3 of 0x10 clears the matching pending bit. Zero bits leave pending bits unchanged.
- R10: The action word and the interrupt clear word read zero. Writes to 0x04 and 0x14 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_par_err | input | 1 | Parity error strobe |
| ev_frm_err | input | 1 | Framing error strobe |
| ev_rx_ovr | input | 1 | Receive overrun strobe |
| ev_tx_ovr | input | 1 | Transmit overrun strobe |
| ev_tx_done | input | 1 | Transmit-done strobe |
| ev_rx_ready | input | 1 | Receive-ready strobe |
| ev_txbuf_free | input | 1 | Transmit-buffer-free strobe |
| rx_enable | output | 1 | Receiver enable state |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |
| irq_txbuf | output | 1 | Transmit-buffer interrupt |

## Verification
The hardest case to reach is a flag being set and cleared in the same clock. The stimulus has to hold an error strobe high while the same cycle carries a write to the action word. The bench has a single step task that drives a register write and any set of strobes on one edge, so these collisions are ordinary stimulus. The bench also sweeps every check-enable pattern, both receiver-enable states and every non-empty set of error strobes. In this way each gating path is reached with every flag both masked and unmasked.

// File: rtl/usi_pkg.sv
package usi_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int N_ERR     = 4;
    localparam int N_RX_ERR  = 3;
    localparam int N_IRQ     = 4;
    localparam int IRQ_ERR   = 2;

    // flag / check-enable bit positions: parity, framing, rx overrun, tx overrun
    localparam int ERR_POS [N_ERR] = '{16, 17, 19, 20};
    // action-word bits that clear each flag, same order
    localparam int ERR_CLR [N_ERR] = '{2, 3, 5, 6};
    localparam int ACT_CLR_REN = 0;
    localparam int ACT_SET_REN = 1;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CTRL  = 8'h00,
        OFS_FLAGS = 8'h04,
        OFS_ACT   = 8'h08,
        OFS_IEN   = 8'h0C,
        OFS_ICLR  = 8'h10,
        OFS_IPEND = 8'h14
    } reg_ofs_e;
endpackage

// File: rtl/usi_cfg_regs.sv
module usi_cfg_regs
    import usi_pkg::*;
#(
    parameter int NE = N_ERR,
    parameter int NI = N_IRQ
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_ien,
    input  logic [NE-1:0] chk_d,
    input  logic [NI-1:0] ien_d,
    output logic [NE-1:0] chk_en,
    output logic [NI-1:0] irq_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       chk_en <= '0;
        else if (wr_ctrl) chk_en <= chk_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      irq_en <= '0;
        else if (wr_ien) irq_en <= ien_d;
    end
endmodule

// File: rtl/usi_err_flags.sv
module usi_err_flags
    import usi_pkg::*;
#(
    parameter int NE  = N_ERR,
    parameter int NRX = N_RX_ERR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] err_ev,
    input  logic [NE-1:0] chk_en,
    input  logic [NE-1:0] clr,
    input  logic          set_ren,
    input  logic          clr_ren,
    output logic [NE-1:0] flags,
    output logic          rx_en,
    output logic          err_hit
);
    logic [NE-1:0] hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rx_en <= 1'b0;
        else if (set_ren) rx_en <= 1'b1;
        else if (clr_ren) rx_en <= 1'b0;
    end

    for (genvar g = 0; g < NE; g++) begin : g_flag
        if (g < NRX) begin : g_rx
            assign hit[g] = err_ev[g] & chk_en[g] & rx_en;
        end else begin : g_tx
            assign hit[g] = err_ev[g] & chk_en[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[g] <= 1'b0;
            else if (hit[g]) flags[g] <= 1'b1;
            else if (clr[g]) flags[g] <= 1'b0;
        end
    end

    assign err_hit = |hit;
endmodule

// File: rtl/usi_irq_pend.sv
module usi_irq_pend
    import usi_pkg::*;
#(
    parameter int NI = N_IRQ
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] ev,
    input  logic [NI-1:0] clr,
    input  logic [NI-1:0] en,
    output logic [NI-1:0] pend,
    output logic [NI-1:0] irq
);
    for (genvar g = 0; g < NI; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pend[g] <= 1'b0;
            else if (ev[g])  pend[g] <= 1'b1;
            else if (clr[g]) pend[g] <= 1'b0;
        end
        assign irq[g] = pend[g] & en[g];
    end
endmodule

// File: rtl/usi_top.sv
module usi_top
    import usi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_par_err,
    input  logic              ev_frm_err,
    input  logic              ev_rx_ovr,
    input  logic              ev_tx_ovr,
    input  logic              ev_tx_done,
    input  logic              ev_rx_ready,
    input  logic              ev_txbuf_free,
    output logic              rx_enable,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err,
    output logic              irq_txbuf
);
    logic              wr_ctrl, wr_act, wr_ien, wr_iclr;
    logic [N_ERR-1:0]  chk_d, act_clr, chk_en, flags;
    logic [N_IRQ-1:0]  irq_en, pend, irq_vec, irq_ev, iclr;
    logic              err_hit;
    logic              unused_wdata;

    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_act  = reg_wr && (reg_addr == OFS_ACT);
    assign wr_ien  = reg_wr && (reg_addr == OFS_IEN);
    assign wr_iclr = reg_wr && (reg_addr == OFS_ICLR);

    for (genvar g = 0; g < N_ERR; g++) begin : g_wd
        assign chk_d[g]   = reg_wdata[ERR_POS[g]];
        assign act_clr[g] = wr_act & reg_wdata[ERR_CLR[g]];
    end

    assign iclr         = {N_IRQ{wr_iclr}} & reg_wdata[N_IRQ-1:0];
    assign unused_wdata = ^reg_wdata;

    usi_cfg_regs #(.NE(N_ERR), .NI(N_IRQ)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_ien  (wr_ien),
        .chk_d   (chk_d),
        .ien_d   (reg_wdata[N_IRQ-1:0]),
        .chk_en  (chk_en),
        .irq_en  (irq_en)
    );

    usi_err_flags #(.NE(N_ERR), .NRX(N_RX_ERR)) err_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_ev  ({ev_tx_ovr, ev_rx_ovr, ev_frm_err, ev_par_err}),
        .chk_en  (chk_en),
        .clr     (act_clr),
        .set_ren (wr_act & reg_wdata[ACT_SET_REN]),
        .clr_ren (wr_act & reg_wdata[ACT_CLR_REN]),
        .flags   (flags),
        .rx_en   (rx_enable),
        .err_hit (err_hit)
    );

    assign irq_ev = {ev_txbuf_free, err_hit, ev_rx_ready, ev_tx_done};

    usi_irq_pend #(.NI(N_IRQ)) irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (irq_ev),
        .clr   (iclr),
        .en    (irq_en),
        .pend  (pend),
        .irq   (irq_vec)
    );

    assign irq_tx    = irq_vec[0];
    assign irq_rx    = irq_vec[1];
    assign irq_err   = irq_vec[IRQ_ERR];
    assign irq_txbuf = irq_vec[3];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: begin
                for (int i = 0; i < N_ERR; i++) reg_rdata[ERR_POS[i]] = chk_en[i];
            end
            OFS_FLAGS: begin
                reg_rdata[0] = rx_enable;
                for (int i = 0; i < N_ERR; i++) reg_rdata[ERR_POS[i]] = flags[i];
            end
            OFS_IEN:   reg_rdata[N_IRQ-1:0] = irq_en;
            OFS_IPEND: reg_rdata[N_IRQ-1:0] = pend;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/usi_chk.sv
module usi_chk
    import usi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              ev_par_err,
    input logic              ev_rx_ovr,
    input logic              ev_tx_done,
    input logic              ev_rx_ready,
    input logic              rx_enable,
    input logic              irq_rx,
    input logic [N_ERR-1:0]  chk_en,
    input logic [N_ERR-1:0]  flags,
    input logic [N_IRQ-1:0]  irq_en,
    input logic [N_IRQ-1:0]  pend
);
    AST_PE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_par_err && chk_en[0] && rx_enable) |=> flags[0]); // R3

    AST_ROE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[2] && !(ev_rx_ovr && chk_en[2])) |=> !flags[2]); // R3

    AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !(reg_wr && reg_addr == OFS_ACT && reg_wdata[3])) |=> flags[1]); // R4

    AST_REN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_ACT && reg_wdata[1]) |=> rx_enable); // R5

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_done |=> pend[0]); // R6

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> irq_en[1]); // R7

    AST_ICLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_ICLR && reg_wdata[1] && !ev_rx_ready) |=> !pend[1]); // R9
endmodule

bind usi_top usi_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .ev_par_err  (ev_par_err),
    .ev_rx_ovr   (ev_rx_ovr),
    .ev_tx_done  (ev_tx_done),
    .ev_rx_ready (ev_rx_ready),
    .rx_enable   (rx_enable),
    .irq_rx      (irq_rx),
    .chk_en      (chk_en),
    .flags       (flags),
    .irq_en      (irq_en),
    .pend        (pend)
);

// File: tb/usi_top_tb_top.sv
module usi_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_par_err = 0, ev_frm_err = 0, ev_rx_ovr = 0, ev_tx_ovr = 0;
    logic        ev_tx_done = 0, ev_rx_ready = 0, ev_txbuf_free = 0;
    logic        rx_enable, irq_tx, irq_rx, irq_err, irq_txbuf;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [3:0] m_chk, m_flags, m_ien, m_pend;
    logic       m_ren;
    int         pos [4] = '{16, 17, 19, 20};

    always #(CLK_PERIOD/2) clk = ~clk;

    usi_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_par_err(ev_par_err), .ev_frm_err(ev_frm_err), .ev_rx_ovr(ev_rx_ovr),
        .ev_tx_ovr(ev_tx_ovr), .ev_tx_done(ev_tx_done), .ev_rx_ready(ev_rx_ready),
        .ev_txbuf_free(ev_txbuf_free), .rx_enable(rx_enable), .irq_tx(irq_tx),
        .irq_rx(irq_rx), .irq_err(irq_err), .irq_txbuf(irq_txbuf)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [31:0] r = '0;
        case (a)
            8'h00: for (int i = 0; i < 4; i++) r[pos[i]] = m_chk[i];
            8'h04: begin
                r[0] = m_ren;
                for (int i = 0; i < 4; i++) r[pos[i]] = m_flags[i];
            end
            8'h0C: r[3:0] = m_ien;
            8'h14: r[3:0] = m_pend;
            default: r = '0;
        endcase
        return r;
    endfunction

    // one clock: optional write plus strobes; model follows the requirements
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] eerr, input logic [2:0] eirq);
        logic [3:0] gated, clr, iclr, irqev;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        {ev_tx_ovr, ev_rx_ovr, ev_frm_err, ev_par_err} = eerr;
        {ev_txbuf_free, ev_rx_ready, ev_tx_done} = eirq;
        @(posedge clk);
        for (int i = 0; i < 4; i++)
            gated[i] = eerr[i] & m_chk[i] & ((i == 3) ? 1'b1 : m_ren);
        clr  = (wr && a == 8'h08) ? {d[6], d[5], d[3], d[2]} : 4'h0;
        iclr = (wr && a == 8'h10) ? d[3:0] : 4'h0;
        irqev = {eirq[2], |gated, eirq[1], eirq[0]};
        m_flags = (m_flags & ~clr) | gated;
        m_pend  = (m_pend & ~iclr) | irqev;
        if (wr && a == 8'h08) begin
            if (d[1]) m_ren = 1'b1;
            else if (d[0]) m_ren = 1'b0;
        end
        if (wr && a == 8'h00) for (int i = 0; i < 4; i++) m_chk[i] = d[pos[i]];
        if (wr && a == 8'h0C) m_ien = d[3:0];
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
        {ev_tx_ovr, ev_rx_ovr, ev_frm_err, ev_par_err} = '0;
        {ev_txbuf_free, ev_rx_ready, ev_tx_done} = '0;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] ofs [6] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14};
        for (int k = 0; k < 6; k++) begin
            reg_addr = ofs[k];
            #1;
            check(tag, $sformatf("read %h", ofs[k]), reg_rdata, exp_rd(ofs[k]));
        end
        check(tag, "rx_enable", {31'd0, rx_enable}, {31'd0, m_ren});
        check(tag, "irq lines", {28'd0, irq_txbuf, irq_err, irq_rx, irq_tx},
              {28'd0, m_pend & m_ien});
    endtask

    function automatic logic [31:0] ctrl_word(input logic [3:0] c);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++) w[pos[i]] = c[i];
        return w;
    endfunction

    function automatic logic [31:0] clr_word(input logic [3:0] c);
        return {25'd0, c[3], c[2], 1'b0, c[1], c[0], 2'b00};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_chk = 0; m_flags = 0; m_ien = 0; m_pend = 0; m_ren = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        check_all("R1");

        // R2: only the four check bits hold
        step(1, 8'h00, 32'hFFFF_FFFF, 0, 0);
        reg_addr = 8'h00; #1;
        check("R2", "ctrl all ones", reg_rdata, 32'h001B_0000);
        step(1, 8'h00, 32'h0, 0, 0);
        check_all("R2");

        // R10: read-only words ignore writes, action and clear words read zero
        step(1, 8'h04, 32'hFFFF_FFFF, 0, 0);
        step(1, 8'h14, 32'hFFFF_FFFF, 0, 0);
        check_all("R10");

        // R3/R4/R5/R8/R9 sweep over check enables, receiver state and error sets
        for (int c = 0; c < 16; c++) begin
            for (int r = 0; r < 2; r++) begin
                step(1, 8'h00, ctrl_word(c[3:0]), 0, 0);
                step(1, 8'h08, (r == 1) ? 32'h2 : 32'h1, 0, 0);
                for (int e = 1; e < 16; e++) begin
                    step(0, 8'h00, 0, e[3:0], 3'b000);
                    check_all("R3");
                    step(1, 8'h08, clr_word(4'b0101), 0, 0);
                    check_all("R4");
                    step(1, 8'h08, clr_word(4'b1111), 0, 0);
                    step(1, 8'h10, 32'h4, 0, 0);
                    check_all("R8");
                end
            end
        end

        // R5: both receiver-enable bits in one write, set wins
        step(1, 8'h08, 32'h1, 0, 0);
        step(1, 8'h08, 32'h3, 0, 0);
        check_all("R5");

        // R6: event and clear in the same cycle
        step(1, 8'h00, 32'h001B_0000, 0, 0);
        step(0, 8'h00, 0, 4'hF, 3'b111);
        step(1, 8'h08, clr_word(4'hF), 4'hF, 0);
        check_all("R6");
        step(1, 8'h10, 32'hF, 4'h1, 3'b111);
        check_all("R6");

        // R8 + R7: all pending, sweep enables
        for (int k = 0; k < 16; k++) begin
            step(1, 8'h0C, k, 0, 0);
            check_all("R7");
        end

        // R9: partial clear
        step(1, 8'h10, 32'h5, 0, 0);
        check_all("R9");
        step(1, 8'h10, 32'h0, 0, 3'b101);
        check_all("R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule